// File: doc/BRIEF.md
# TDM Frame Timing Generator

This block recovers the 8 kHz frame boundary of a time-division multiplexed backplane from an active-low frame-sync input. All of its logic runs on one 16.384 MHz master clock. Three backplane timing conventions are supported: ST-BUS, CT Bus and HMVIP. They differ in how long the frame-sync input stays low: one, two or four master cycles. A two-bit mode input picks the convention. A low run of any other length is rejected.

An accepted sync pulse aligns a free-running 2048-cycle frame position counter, from which bit and channel indices for 2.048 Mb/s streams are derived. When two boundaries in a row land exactly where the counter expects them, the block reports lock. A boundary that lands anywhere else sets a sticky alignment error, drops lock and realigns the counter. A frame that ends with no sync pulse also drops lock.

From the counter the block regenerates local timing: a 4.096 MHz clock and a 244 ns active-low frame pulse centred on the boundary. The local frame pulse spans the last half-cycle of the local clock in one frame and the first half-cycle in the next.

Top module: `tdm_frame_timer`

## Requirements
- R1: While rst_n is low, frame_pos is 0, locked is 0, align_err is 0, local_fp_n is 0 and local_clk is 0.
- R2: frame_pos advances by one on every master clock edge and wraps from 2047 to 0. A wrap that happens before any sync pulse has been accepted sets neither align_err nor locked.
- R3: When a sync pulse is accepted, frame_pos reads 0 after the clock edge that follows the first edge sampling fp_in_n high again.
- R4: Consider the pulses accepted after the first one (the first only aligns). After two of them in a row arrive while frame_pos is 2047, locked goes to 1 on the same edge that brings frame_pos to 0.
- R5: A low run on fp_in_n whose length differs from the width of the selected mode is ignored: the counter is not realigned and align_err stays 0.
- R6: After the first accepted pulse, a pulse accepted while frame_pos is not 2047 sets align_err, clears locked and realigns frame_pos to 0. align_err then stays 1 until reset.
- R7: Once aligned, a frame in which frame_pos wraps from 2047 with no accepted pulse clears locked and leaves align_err unchanged.
- R8: local_clk is high exactly when frame_pos mod 4 is 2 or 3, which gives a period of four master cycles.
- R9: local_fp_n is low exactly when frame_pos is 2046, 2047, 0 or 1.
- R10: bit_idx equals frame_pos[5:3] and chan_idx equals frame_pos[10:6].
- R11: The mode_sel encoding sets the accepted pulse width: 2'b00 (ST-BUS) accepts 1 cycle, 2'b01 (CT Bus) accepts 2 cycles, 2'b10 (HMVIP) accepts 4 cycles, and 2'b11 accepts no pulse at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Timing convention select |
| fp_in_n | input | 1 | Active-low frame-sync input |
| frame_pos | output | 11 | Master-cycle position within the frame |
| bit_idx | output | 3 | Bit index within the current channel |
| chan_idx | output | 5 | Channel index within the frame |
| local_clk | output | 1 | Regenerated 4.096 MHz clock |
| local_fp_n | output | 1 | Regenerated 244 ns active-low frame pulse |
| locked | output | 1 | Boundaries arriving at the expected position |
| align_err | output | 1 | Sticky misplaced-boundary flag |

## Verification
Take a sync pulse whose first low sample lands on edge 1 and has width W. It is accepted on edge W+1, when fp_in_n is seen high again. Its effect on frame_pos, locked and align_err appears on edge W+2. local_clk and local_fp_n are registered from the next counter value, so they always match frame_pos in the same cycle and never lag it. The bench drives inputs and samples outputs on falling edges, and it counts edges exactly: a pulse task followed by two steps lands on the realigned zero, and each further step adds one to the expected position. The bench also spaces pulses exactly 2048 cycles from start to start, so they meet the expected-position condition.

// File: rtl/tdm_tg_pkg.sv
package tdm_tg_pkg;

    typedef enum logic [1:0] {
        MODE_STBUS = 2'b00,
        MODE_CTBUS = 2'b01,
        MODE_HMVIP = 2'b10,
        MODE_NONE  = 2'b11
    } tmode_e;

    // Required low-run length of the sync pulse, in master cycles (0 = none accepted)
    function automatic logic [2:0] pulse_width(input tmode_e m);
        case (m)
            MODE_STBUS: pulse_width = 3'd1;
            MODE_CTBUS: pulse_width = 3'd2;
            MODE_HMVIP: pulse_width = 3'd4;
            default:    pulse_width = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/tdm_fp_qualifier.sv
module tdm_fp_qualifier
    import tdm_tg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       fp_in_n,
    output logic       evt
);
    localparam int LW = 3;
    localparam logic [LW-1:0] LMAX = '1;

    typedef struct packed {
        logic          fp_s;
        logic [LW-1:0] low;
    } st_t;

    st_t st_d, st_q;
    logic [2:0] width;

    always_comb begin
        width = pulse_width(tmode_e'(mode_sel));
        st_d  = st_q;
        st_d.fp_s = fp_in_n;
        if (!st_q.fp_s) begin
            st_d.low = (st_q.low == LMAX) ? st_q.low : st_q.low + 1'b1;
        end else begin
            st_d.low = '0;
        end
        evt = st_q.fp_s && (width != 3'd0) && (st_q.low == width);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fp_s: 1'b1, low: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // An accepted boundary is a single-cycle event
    assert_single_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

endmodule

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
    parameter int FRAME_LEN = 2048,
    parameter int LOCK_RUN  = 2,
    localparam int CW = $clog2(FRAME_LEN),
    localparam int RW = $clog2(LOCK_RUN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    output logic [CW-1:0] cnt_cur,
    output logic [CW-1:0] cnt_nxt,
    output logic          locked,
    output logic          err
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_RUN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          aligned;
        logic [RW-1:0] run;
        logic          locked;
        logic          err;
    } st_t;

    st_t st_d, st_q;
    logic at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == LAST);
        st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
        if (evt) begin
            st_d.cnt = '0;
            if (!st_q.aligned) begin
                st_d.aligned = 1'b1;
                st_d.run     = '0;
            end else if (at_end) begin
                if (st_q.run != RUN_MAX) st_d.run = st_q.run + 1'b1;
            end else begin
                st_d.err = 1'b1;
                st_d.run = '0;
            end
        end else if (at_end && st_q.aligned) begin
            st_d.run = '0;
        end
        st_d.locked = (st_d.run == RUN_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_cur = st_q.cnt;
    assign cnt_nxt = st_d.cnt;
    assign locked  = st_q.locked;
    assign err     = st_q.err;

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LAST && !evt) |=> st_q.cnt == '0);
    assert_realign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> st_q.cnt == '0);
    assert_lock_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> st_q.cnt == '0);
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);
    assert_miss_unlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && st_q.cnt == LAST && !evt) |=> !st_q.locked);

endmodule

// File: rtl/tdm_local_out.sv
module tdm_local_out #(
    parameter int FRAME_LEN = 2048,
    parameter int CLK_DIV   = 4,
    localparam int CW   = $clog2(FRAME_LEN),
    localparam int HB   = $clog2(CLK_DIV),
    localparam int HALF = CLK_DIV / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [CW-1:0] cnt_cur,
    output logic          lclk,
    output logic          lfp_n
);
    localparam logic [CW-1:0] WIN_LO = CW'(FRAME_LEN - HALF);
    localparam logic [CW-1:0] WIN_HI = CW'(HALF);

    typedef struct packed {
        logic lclk;
        logic lfp_n;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.lclk  = cnt_nxt[HB-1];
        st_d.lfp_n = !((cnt_nxt >= WIN_LO) || (cnt_nxt < WIN_HI));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lclk: 1'b0, lfp_n: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lclk  = st_q.lclk;
    assign lfp_n = st_q.lfp_n;

    assert_lclk_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lclk) |-> cnt_cur[HB-1:0] == HB'(HALF));
    assert_lfp_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lfp_n) |-> cnt_cur == WIN_HI);

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
    parameter int FRAME_LEN   = 2048,
    parameter int CYC_PER_BIT = 8,
    parameter int BITS_PER_CH = 8,
    parameter int CLK_DIV     = 4,
    parameter int LOCK_RUN    = 2,
    localparam int CW     = $clog2(FRAME_LEN),
    localparam int BIT_SH = $clog2(CYC_PER_BIT),
    localparam int BW     = $clog2(BITS_PER_CH),
    localparam int CH_SH  = BIT_SH + BW,
    localparam int CHW    = CW - CH_SH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     mode_sel,
    input  logic           fp_in_n,
    output logic [CW-1:0]  frame_pos,
    output logic [BW-1:0]  bit_idx,
    output logic [CHW-1:0] chan_idx,
    output logic           local_clk,
    output logic           local_fp_n,
    output logic           locked,
    output logic           align_err
);
    logic          evt;
    logic [CW-1:0] cnt_cur, cnt_nxt;

    tdm_fp_qualifier u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .fp_in_n  (fp_in_n),
        .evt      (evt)
    );

    tdm_frame_counter #(
        .FRAME_LEN (FRAME_LEN),
        .LOCK_RUN  (LOCK_RUN)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .cnt_cur (cnt_cur),
        .cnt_nxt (cnt_nxt),
        .locked  (locked),
        .err     (align_err)
    );

    tdm_local_out #(
        .FRAME_LEN (FRAME_LEN),
        .CLK_DIV   (CLK_DIV)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_nxt (cnt_nxt),
        .cnt_cur (cnt_cur),
        .lclk    (local_clk),
        .lfp_n   (local_fp_n)
    );

    assign frame_pos = cnt_cur;
    assign bit_idx   = cnt_cur[CH_SH-1:BIT_SH];
    assign chan_idx  = cnt_cur[CW-1:CH_SH];

endmodule

// File: tb/sim_tdm_frame_timer.sv
module sim_tdm_frame_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        fp_in_n = 1'b1;
    logic [10:0] frame_pos;
    logic [2:0]  bit_idx;
    logic [4:0]  chan_idx;
    logic        local_clk, local_fp_n, locked, align_err;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tdm_frame_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .fp_in_n    (fp_in_n),
        .frame_pos  (frame_pos),
        .bit_idx    (bit_idx),
        .chan_idx   (chan_idx),
        .local_clk  (local_clk),
        .local_fp_n (local_fp_n),
        .locked     (locked),
        .align_err  (align_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        fp_in_n = 1'b1;
        mode_sel = m;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input int w);
        fp_in_n = 1'b0;
        step(w);
        fp_in_n = 1'b1;
    endtask

    // First pulse aligns; two more spaced one frame apart give lock
    task automatic lock_stbus();
        pulse(1); step(2);
        step(2045); pulse(1); step(2);
        step(2045); pulse(1); step(2);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(2);
        chk("R1 frame_pos in reset", frame_pos, 0);
        chk("R1 locked in reset", locked, 0);
        chk("R1 align_err in reset", align_err, 0);
        chk("R1 local_fp_n in reset", local_fp_n, 0);
        chk("R1 local_clk in reset", local_clk, 0);
        rst_n = 1'b1;
        step(5);
        chk("R2 count after 5 edges", frame_pos, 5);
    endtask

    task automatic t_freerun();
        do_reset(2'b00);
        step(2047);
        chk("R2 count at end of frame", frame_pos, 2047);
        step(1);
        chk("R2 wrap to zero", frame_pos, 0);
        chk("R2 no error on unaligned wrap", align_err, 0);
        chk("R2 no lock on unaligned wrap", locked, 0);
    endtask

    task automatic t_stbus_lock();
        do_reset(2'b00);
        step(100);
        pulse(1); step(2);
        chk("R3 realign on first pulse", frame_pos, 0);
        chk("R4 not locked after align", locked, 0);
        step(2045); pulse(1); step(2);
        chk("R3 zero at second pulse", frame_pos, 0);
        chk("R4 not locked after one match", locked, 0);
        step(2045); pulse(1); step(2);
        chk("R4 locked after two matches", locked, 1);
        chk("R4 no error on good pulses", align_err, 0);
        step(200);
        chk("R10 frame_pos 200", frame_pos, 200);
        chk("R10 bit_idx", bit_idx, 1);
        chk("R10 chan_idx", chan_idx, 3);
        chk("R8 local_clk low at pos mod 4 = 0", local_clk, 0);
        step(2);
        chk("R8 local_clk high at pos mod 4 = 2", local_clk, 1);
        step(1);
        chk("R8 local_clk high at pos mod 4 = 3", local_clk, 1);
        step(1842);
        chk("R9 local_fp_n high at 2045", local_fp_n, 1);
        step(1);
        chk("R9 local_fp_n low at 2046", local_fp_n, 0);
        step(2);
        chk("R9 pos 0 after wrap", frame_pos, 0);
        chk("R9 local_fp_n low at 0", local_fp_n, 0);
        chk("R7 missed pulse drops lock", locked, 0);
        chk("R7 missed pulse sets no error", align_err, 0);
        step(1);
        chk("R9 local_fp_n low at 1", local_fp_n, 0);
        step(1);
        chk("R9 local_fp_n high at 2", local_fp_n, 1);
    endtask

    task automatic t_width_modes();
        do_reset(2'b01);
        step(50);
        pulse(1); step(2);
        chk("R5 short pulse ignored in CT mode", frame_pos, 53);
        chk("R5 short pulse sets no error", align_err, 0);
        pulse(2); step(2);
        chk("R11 CT mode accepts width 2", frame_pos, 0);
        do_reset(2'b10);
        step(30);
        pulse(2); step(2);
        chk("R5 width 2 ignored in HMVIP mode", frame_pos, 34);
        pulse(4); step(2);
        chk("R11 HMVIP mode accepts width 4", frame_pos, 0);
        do_reset(2'b00);
        step(10);
        pulse(3); step(2);
        chk("R5 width 3 ignored in ST-BUS mode", frame_pos, 15);
        do_reset(2'b11);
        step(10);
        pulse(1); step(2);
        pulse(2); step(2);
        pulse(4); step(2);
        chk("R11 reserved mode accepts nothing", frame_pos, 23);
        chk("R11 reserved mode no error", align_err, 0);
    endtask

    task automatic t_misplaced();
        do_reset(2'b00);
        step(7);
        lock_stbus();
        chk("R4 locked before misplaced pulse", locked, 1);
        step(497);
        pulse(1); step(2);
        chk("R6 realign on misplaced pulse", frame_pos, 0);
        chk("R6 error set", align_err, 1);
        chk("R6 lock cleared", locked, 0);
        step(2045); pulse(1); step(2);
        chk("R6 error stays set", align_err, 1);
        chk("R6 pos zero after good pulse", frame_pos, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_freerun();
        t_stbus_lock();
        t_width_modes();
        t_misplaced();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule